// File: doc/BRIEF.md
# Load String Word Sequencer

This block carries out a load-string-word operation on behalf of a core with a 32-entry, 64-bit register file. When started it fetches a run of bytes from a byte-wide synchronous memory, one read per cycle from consecutive addresses. It packs them four at a time, first byte in the most significant lane, into the low 32 bits of successive destination registers. Each finished word goes out through a single register-file write port. The upper 32 bits of every written register are cleared.

The byte count comes either from a 5-bit immediate field, where zero stands for 32, or from a separate count operand holding a true byte count. The destination index runs past 31 back to 0. Up to two address-source registers can be marked as protected. The sequence halts rather than write one of them, and the second index only applies in register-count mode. When the little-endian flag is set at start, nothing is read or written and a fault pulse is raised in place of completion.

Top module: `lsw_seq`

## Requirements
- R1: Each written register holds its bytes in the low 32 bits, the first fetched byte in bits 31:24, the next in 23:16, and so on; bits 63:32 are written as zero.
- R2: When the final word receives fewer than four bytes, its unfilled low-order lanes are zero.
- R3: A count of n bytes writes ceil(n/4) registers at consecutive indices starting from the start index, each exactly once and in order.
- R4: The destination index following 31 is 0.
- R5: In immediate mode (`imm_mode_i`=1) a field value of 0 loads 32 bytes into exactly 8 registers; the ninth register is not written.
- R6: In register-count mode (`imm_mode_i`=0) `reg_cnt_i` is a byte count: 32 writes 8 registers. A count of 0 writes nothing, issues no read, and still gives a done pulse.
- R7: If `little_end_i` is 1 when a start is accepted, a fault pulse follows in the next cycle, with no memory read and no register write.
- R8: Before the first byte of a word whose destination equals an enabled protected index, the sequence stops: that word and all later ones are neither read nor written, and done follows. Protected index A is honoured in both modes; index B only in register-count mode.
- R9: Reads start at the effective address and step by one, modulo 2^AW. Each accepted read has its byte on `mem_rdata_i` in the following cycle. The number of reads equals the number of bytes placed in written registers.
- R10: A start pulse while `busy_o` is 1 is ignored and has no effect on the running operation.
- R11: After reset, `busy_o`, `done_o`, `fault_o`, `mem_req_o` and `rf_we_o` are 0. `done_o` and `fault_o` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, taken only when idle |
| dest_i | input | 5 | First destination register index |
| addr_i | input | AW | Effective byte address |
| imm_mode_i | input | 1 | 1 = immediate count field, 0 = count operand |
| imm_cnt_i | input | 5 | Immediate byte count, 0 meaning 32 |
| reg_cnt_i | input | CNT_W | Byte count operand |
| little_end_i | input | 1 | Little-endian mode: fault instead of load |
| prot_a_en_i | input | 1 | Enable protection of index A |
| prot_a_i | input | 5 | Protected index A |
| prot_b_en_i | input | 1 | Enable protection of index B (count-operand mode) |
| prot_b_i | input | 5 | Protected index B |
| mem_req_o | output | 1 | Byte read request |
| mem_addr_o | output | AW | Byte read address |
| mem_rdata_i | input | 8 | Read byte, valid the cycle after the request |
| rf_we_o | output | 1 | Register write strobe |
| rf_idx_o | output | 5 | Register write index |
| rf_wdata_o | output | 64 | Register write data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Completion pulse |
| fault_o | output | 1 | Alignment fault pulse |

## Verification
The bench builds the block with AW=16 and CNT_W=7. The 16-bit address lets one run start at 0xFFFE and cross the top of the address space, so the byte stream continues from 0x0000. The 7-bit count reaches 127 bytes, which is 32 words: every register index is written once and the destination wraps fully around. A stray start request fired during that long run has time to show whether it is ignored.

// File: rtl/lsw_pkg.sv
package lsw_pkg;
  localparam int WORD_BYTES = 4;
  localparam int WORD_W     = 8 * WORD_BYTES;
  localparam int XLEN       = 64;
  localparam int NREG       = 32;
  localparam int RIDX_W     = $clog2(NREG);
  localparam int LANE_W     = $clog2(WORD_BYTES);

  typedef logic [RIDX_W-1:0] ridx_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LANE_W-1:0] lane_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} seq_st_t;

  // Next destination index, running past the last register back to 0.
  function automatic ridx_t next_reg(input ridx_t r);
    return (r == ridx_t'(NREG - 1)) ? '0 : r + ridx_t'(1);
  endfunction

  // Merge one byte into its lane; lane 0 is the most significant byte.
  function automatic word_t put_byte(input word_t w, input logic [7:0] b,
                                     input lane_t lane);
    int unsigned sh;
    sh = 8 * (WORD_BYTES - 1 - int'(lane));
    return w | (word_t'(b) << sh);
  endfunction

  // Effective byte count of an operation.
  function automatic logic [15:0] byte_count(input logic imm_mode,
                                             input logic [4:0] imm,
                                             input logic [15:0] opnd);
    if (imm_mode) return (imm == 5'd0) ? 16'd32 : {11'd0, imm};
    return opnd;
  endfunction

  // True when an index collides with an enabled protected index.
  function automatic logic prot_match(input ridx_t r, input logic a_en,
                                      input ridx_t a, input logic b_en,
                                      input ridx_t b);
    return (a_en && (r == a)) || (b_en && (r == b));
  endfunction
endpackage

// File: rtl/lsw_issue.sv
module lsw_issue
  import lsw_pkg::*;
#(
  parameter int AW    = 16,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [AW-1:0]    base_i,
  input  logic [CNT_W-1:0] count_i,
  input  ridx_t            dest_i,
  input  logic             pa_en_i,
  input  ridx_t            pa_i,
  input  logic             pb_en_i,
  input  ridx_t            pb_i,
  output logic             req_o,
  output logic [AW-1:0]    addr_o,
  output logic             end_o,
  output logic             idle_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] left_q;
  logic [AW-1:0]    addr_q;
  ridx_t            reg_q;
  lane_t            pos_q;

  logic active;
  assign active = (left_q != '0);
  assign hit_o  = active && (pos_q == '0) &&
                  prot_match(reg_q, pa_en_i, pa_i, pb_en_i, pb_i);
  assign req_o  = active && !hit_o;
  assign end_o  = req_o && ((pos_q == lane_t'(WORD_BYTES - 1)) ||
                            (left_q == CNT_W'(1)));
  assign addr_o = addr_q;
  assign idle_o = !active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      addr_q <= '0;
      reg_q  <= '0;
      pos_q  <= '0;
    end else if (load_i) begin
      left_q <= count_i;
      addr_q <= base_i;
      reg_q  <= dest_i;
      pos_q  <= '0;
    end else if (hit_o) begin
      left_q <= '0;
    end else if (req_o) begin
      left_q <= left_q - CNT_W'(1);
      addr_q <= addr_q + AW'(1);
      pos_q  <= pos_q + lane_t'(1);
      if (pos_q == lane_t'(WORD_BYTES - 1)) reg_q <= next_reg(reg_q);
    end
  end
endmodule

// File: rtl/lsw_pack.sv
module lsw_pack
  import lsw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  ridx_t            dest_i,
  input  logic             req_i,
  input  logic             end_i,
  input  logic [7:0]       rdata_i,
  output logic             pend_o,
  output logic             we_o,
  output ridx_t            idx_o,
  output logic [XLEN-1:0]  wdata_o
);
  logic            v_q, e_q, we_q;
  lane_t           lane_q;
  word_t           acc_q, merged;
  ridx_t           reg_q, idx_q;
  logic [XLEN-1:0] wdata_q;

  assign merged  = put_byte(acc_q, rdata_i, lane_q);
  assign pend_o  = v_q;
  assign we_o    = we_q;
  assign idx_o   = idx_q;
  assign wdata_o = wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q     <= 1'b0;
      e_q     <= 1'b0;
      we_q    <= 1'b0;
      lane_q  <= '0;
      acc_q   <= '0;
      reg_q   <= '0;
      idx_q   <= '0;
      wdata_q <= '0;
    end else begin
      v_q  <= req_i;
      e_q  <= end_i;
      we_q <= 1'b0;
      if (load_i) begin
        reg_q  <= dest_i;
        lane_q <= '0;
        acc_q  <= '0;
      end else if (v_q) begin
        if (e_q) begin
          we_q    <= 1'b1;
          idx_q   <= reg_q;
          wdata_q <= {{(XLEN-WORD_W){1'b0}}, merged};
          acc_q   <= '0;
          lane_q  <= '0;
          reg_q   <= next_reg(reg_q);
        end else begin
          acc_q  <= merged;
          lane_q <= lane_q + lane_t'(1);
        end
      end
    end
  end
endmodule

// File: rtl/lsw_seq.sv
module lsw_seq
  import lsw_pkg::*;
#(
  parameter int AW    = 16,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [4:0]       dest_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             imm_mode_i,
  input  logic [4:0]       imm_cnt_i,
  input  logic [CNT_W-1:0] reg_cnt_i,
  input  logic             little_end_i,
  input  logic             prot_a_en_i,
  input  logic [4:0]       prot_a_i,
  input  logic             prot_b_en_i,
  input  logic [4:0]       prot_b_i,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  input  logic [7:0]       mem_rdata_i,
  output logic             rf_we_o,
  output logic [4:0]       rf_idx_o,
  output logic [63:0]      rf_wdata_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             fault_o
);
  seq_st_t    state_q;
  logic       done_q, fault_q;
  logic       prot_a_en_q, prot_b_en_q;
  ridx_t      prot_a_q, prot_b_q;

  logic       accept, load;
  logic       iss_req, iss_end, iss_idle, iss_hit, pend;
  logic [CNT_W-1:0] eff_cnt;

  assign accept  = start_i && (state_q == ST_IDLE);
  assign load    = accept && !little_end_i;
  assign eff_cnt = CNT_W'(byte_count(imm_mode_i, imm_cnt_i, 16'(reg_cnt_i)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      done_q      <= 1'b0;
      fault_q     <= 1'b0;
      prot_a_en_q <= 1'b0;
      prot_b_en_q <= 1'b0;
      prot_a_q    <= '0;
      prot_b_q    <= '0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      if (accept) begin
        if (little_end_i) begin
          fault_q <= 1'b1;
        end else begin
          state_q     <= ST_RUN;
          prot_a_en_q <= prot_a_en_i;
          prot_a_q    <= prot_a_i;
          prot_b_en_q <= prot_b_en_i && !imm_mode_i;
          prot_b_q    <= prot_b_i;
        end
      end else if (state_q == ST_RUN && iss_idle && !pend) begin
        state_q <= ST_IDLE;
        done_q  <= 1'b1;
      end
    end
  end

  lsw_issue #(.AW(AW), .CNT_W(CNT_W)) u_issue (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .base_i  (addr_i),
    .count_i (eff_cnt),
    .dest_i  (dest_i),
    .pa_en_i (prot_a_en_q),
    .pa_i    (prot_a_q),
    .pb_en_i (prot_b_en_q),
    .pb_i    (prot_b_q),
    .req_o   (iss_req),
    .addr_o  (mem_addr_o),
    .end_o   (iss_end),
    .idle_o  (iss_idle),
    .hit_o   (iss_hit)
  );

  lsw_pack u_pack (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .dest_i  (dest_i),
    .req_i   (iss_req),
    .end_i   (iss_end),
    .rdata_i (mem_rdata_i),
    .pend_o  (pend),
    .we_o    (rf_we_o),
    .idx_o   (rf_idx_o),
    .wdata_o (rf_wdata_o)
  );

  assign mem_req_o = iss_req;
  assign busy_o    = (state_q == ST_RUN);
  assign done_o    = done_q;
  assign fault_o   = fault_q;
endmodule

// File: rtl/lsw_seq_chk.sv
module lsw_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          little_end_i,
  input logic          busy_o,
  input logic          mem_req_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          rf_we_o,
  input logic [4:0]    rf_idx_o,
  input logic [63:0]   rf_wdata_o,
  input logic          done_o,
  input logic          fault_o,
  input logic          pa_en,
  input logic [4:0]    pa,
  input logic          pb_en,
  input logic [4:0]    pb,
  input logic          hit
);
  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o |-> (rf_wdata_o[63:32] == 32'd0));

  a_r8_keep_a: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we_o && pa_en) |-> (rf_idx_o != pa));

  a_r8_keep_b: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we_o && pb_en) |-> (rf_idx_o != pb));

  a_r8_halt: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !mem_req_o);

  a_r7_le_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && little_end_i) |=> (fault_o && !busy_o));

  a_r7_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (!mem_req_o && !rf_we_o));

  a_r9_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && $past(mem_req_o)) |-> (mem_addr_o == $past(mem_addr_o) + AW'(1)));

  a_r10_req_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> busy_o);

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r11_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |=> !fault_o);
endmodule

bind lsw_seq lsw_seq_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .little_end_i (little_end_i),
  .busy_o       (busy_o),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .rf_we_o      (rf_we_o),
  .rf_idx_o     (rf_idx_o),
  .rf_wdata_o   (rf_wdata_o),
  .done_o       (done_o),
  .fault_o      (fault_o),
  .pa_en        (prot_a_en_q),
  .pa           (prot_a_q),
  .pb_en        (prot_b_en_q),
  .pb           (prot_b_q),
  .hit          (iss_hit)
);

// File: tb/lsw_seq_tb_top.sv
module lsw_seq_tb_top;
  localparam int AW    = 16;
  localparam int CNT_W = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic             start_i = 0, imm_mode_i = 0, little_end_i = 0;
  logic [4:0]       dest_i = 0, imm_cnt_i = 0, prot_a_i = 0, prot_b_i = 0;
  logic             prot_a_en_i = 0, prot_b_en_i = 0;
  logic [AW-1:0]    addr_i = 0;
  logic [CNT_W-1:0] reg_cnt_i = 0;
  logic             mem_req_o, rf_we_o, busy_o, done_o, fault_o;
  logic [AW-1:0]    mem_addr_o;
  logic [7:0]       mem_rdata_i;
  logic [4:0]       rf_idx_o;
  logic [63:0]      rf_wdata_o;

  lsw_seq #(.AW(AW), .CNT_W(CNT_W)) dut_i (.*);

  function automatic logic [7:0] byte_at(input logic [AW-1:0] a);
    return a[7:0] + 8'd1;
  endfunction

  always_ff @(posedge clk) if (mem_req_o) mem_rdata_i <= byte_at(mem_addr_o);

  typedef struct packed { logic [4:0] idx; logic [63:0] data; } wr_t;
  wr_t exp_q[$];

  int errors = 0, checks = 0, seen_reads = 0, exp_reads = 0;
  logic [AW-1:0] next_addr = 0;
  string cur_tag = "";

  task automatic chk(input logic ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every register write, follows reads.
  always @(negedge clk) begin
    if (rst_n) begin
      if (rf_we_o) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, {cur_tag, " R3 unexpected write"}, {59'd0, rf_idx_o}, 64'd0);
        end else begin
          wr_t e;
          e = exp_q.pop_front();
          chk(rf_idx_o == e.idx, {cur_tag, " R3 index"}, {59'd0, rf_idx_o}, {59'd0, e.idx});
          chk(rf_wdata_o == e.data, {cur_tag, " R1 data"}, rf_wdata_o, e.data);
        end
      end
      if (mem_req_o) begin
        seen_reads++;
        if (mem_addr_o != next_addr)
          chk(1'b0, {cur_tag, " R9 address"}, 64'(mem_addr_o), 64'(next_addr));
        next_addr = next_addr + AW'(1);
      end
    end
  end

  task automatic run_op(input string tag, input logic [4:0] dest,
                        input logic [AW-1:0] base, input logic immm,
                        input logic [4:0] imm, input logic [CNT_W-1:0] rc,
                        input logic le, input logic pae, input logic [4:0] pa,
                        input logic pbe, input logic [4:0] pb, input logic poke);
    int n, words;
    logic got_done, got_fault;
    cur_tag = tag;
    n = immm ? ((imm == 0) ? 32 : int'(imm)) : int'(rc);
    words = (n + 3) / 4;
    exp_reads = 0;
    if (!le) begin
      for (int w = 0; w < words; w++) begin
        logic [4:0] r;
        logic [31:0] word;
        r = 5'((int'(dest) + w) % 32);
        if ((pae && r == pa) || (pbe && !immm && r == pb)) break;
        word = 0;
        for (int k = 0; k < 4; k++) begin
          word = word << 8;
          if (4 * w + k < n) begin
            word[7:0] = byte_at(base + AW'(4 * w + k));
            exp_reads++;
          end
        end
        exp_q.push_back('{idx: r, data: {32'd0, word}});
      end
    end
    seen_reads = 0;
    next_addr = base;
    @(posedge clk); #1;
    start_i = 1; dest_i = dest; addr_i = base; imm_mode_i = immm; imm_cnt_i = imm;
    reg_cnt_i = rc; little_end_i = le; prot_a_en_i = pae; prot_a_i = pa;
    prot_b_en_i = pbe; prot_b_i = pb;
    @(posedge clk); #1;
    start_i = 0; little_end_i = 0;
    got_done = 0; got_fault = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (poke && i == 3) begin start_i = 1; little_end_i = 1; dest_i = dest + 5'd7; end
      if (poke && i == 4) begin start_i = 0; little_end_i = 0; end
      if (done_o || fault_o) begin got_done = done_o; got_fault = fault_o; break; end
    end
    chk(got_fault == le, {tag, " R7 fault"}, 64'(got_fault), 64'(le));
    chk(got_done == !le, {tag, " R11 done"}, 64'(got_done), 64'(!le));
    @(negedge clk);
    chk(!done_o && !fault_o, {tag, " R11 pulse width"}, 64'({done_o, fault_o}), 64'd0);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, {tag, " R3 missing writes"}, 64'(exp_q.size()), 64'd0);
    chk(seen_reads == exp_reads, {tag, " R9 read count"}, 64'(seen_reads), 64'(exp_reads));
    exp_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk({busy_o, done_o, fault_o, mem_req_o, rf_we_o} == 5'd0, "R11 reset state",
        64'({busy_o, done_o, fault_o, mem_req_o, rf_we_o}), 64'd0);
    // R2: three bytes, last lane zero
    run_op("R2 partial", 5'd11, 16'h0000, 1, 5'd3, 0, 0, 0, 0, 0, 0, 0);
    // R5: immediate zero means 32 bytes
    run_op("R5 imm zero", 5'd11, 16'h0000, 1, 5'd0, 0, 0, 0, 0, 0, 0, 0);
    // R6: count operand is bytes, not registers
    run_op("R6 count 32", 5'd11, 16'h0000, 0, 5'd0, 7'd32, 0, 0, 0, 0, 0, 0);
    // R4: wrap past 31
    run_op("R4 wrap", 5'd31, 16'h0000, 1, 5'd8, 0, 0, 0, 0, 0, 0, 0);
    // R8: protected B in count-operand mode stops before r0
    run_op("R8 prot b", 5'd31, 16'h0000, 0, 5'd0, 7'd12, 0, 0, 0, 1, 5'd0, 0);
    // R8: protected A stops before r1
    run_op("R8 prot a", 5'd31, 16'h0000, 1, 5'd10, 0, 0, 1, 5'd1, 0, 0, 0);
    // R8: index B has no effect in immediate mode
    run_op("R8 b ignored imm", 5'd2, 16'h0040, 1, 5'd8, 0, 0, 0, 0, 1, 5'd3, 0);
    // R7: little-endian faults
    run_op("R7 little endian", 5'd4, 16'h0000, 1, 5'd4, 0, 1, 0, 0, 0, 0, 0);
    // R6: zero count
    run_op("R6 count zero", 5'd4, 16'h0000, 0, 5'd0, 7'd0, 0, 0, 0, 0, 0, 0);
    // R10 and R3: 127 bytes over all registers, stray start mid-run
    run_op("R10 busy start", 5'd5, 16'h0100, 0, 5'd0, 7'd127, 0, 0, 0, 0, 0, 1);
    // R9: address wraps past the top
    run_op("R9 addr wrap", 5'd20, 16'hFFFE, 1, 5'd5, 0, 0, 0, 0, 0, 0, 0);
    // R1: single byte in the top lane
    run_op("R1 one byte", 5'd0, 16'h0033, 1, 5'd1, 0, 0, 0, 0, 0, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule